// File: doc/BRIEF.md
# UART FIFO Control with Receive Trigger Interrupt

This block is the buffering section of a UART register interface. It holds a transmit queue and a receive queue, each sixteen 8-bit characters deep. The serial side of the UART and the bus side both reach the queues through separate push and pop strobes. Each queue reports its fill count and its full and empty flags.

A single 8-bit control register is written through a one-cycle write strobe. Bit 0 is a guard: a write with bit 0 clear changes nothing. A guarded write does four things. It selects the receive trigger threshold, it stores a DMA select bit that has no other effect, and it can request a one-cycle flush of either queue. The receive-data-available interrupt is a level output. It is high while the receive queue holds at least the selected number of characters.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Each queue returns characters in the order they were pushed. The data output shows the oldest entry whenever the queue is not empty. The count output gives the number of stored entries, 0 to 16. Full is high at 16 and empty is high at 0. A push and a pop in the same cycle are both accepted when the queue is neither full nor empty.
- R2: A push while the queue is full is ignored and a pop while the queue is empty is ignored. A queue that is full can still take a pop in the same cycle as a rejected push.
- R3: Control bits [7:6] select the receive threshold: 00 = 1, 01 = 4, 10 = 8, 11 = 14 characters. The interrupt output is high exactly while the receive count is at or above the threshold, and it falls in the same cycle the count drops below it.
- R4: A control write whose bit 0 is 0 has no effect on the threshold, on the DMA bit, or on either queue.
- R5: A guarded write with bit 2 set empties the transmit queue at the next clock edge after the write. Read-back bit 2 is 1 only during the cycle between those two edges and is 0 otherwise.
- R6: A guarded write with bit 1 set empties the receive queue at the next clock edge after the write. Read-back bit 1 is 1 only during the cycle between those two edges.
- R7: The read-back value is {threshold[1:0], 2'b00, dma, tx_flush, rx_flush, 1'b1}. Bit 0 always reads 1. Bit 3 holds the last guarded write of bit 3 and has no effect on the queues or the interrupt.
- R8: After reset the threshold code is 00, the DMA bit is 0, both queues are empty and the read-back value is 8'h01.
- R9: When a flush pulse and a push or pop on the same queue fall in the same cycle, the flush wins and the queue ends the cycle empty.
- R10: When the queue holds between 1 and 15 entries, a push and a pop in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write value |
| ctl_rdata_o | output | 8 | Control register read-back |
| tx_push_i | input | 1 | Push a character into the transmit queue |
| tx_data_i | input | 8 | Character to push into the transmit queue |
| tx_pop_i | input | 1 | Pop the oldest transmit character |
| tx_data_o | output | 8 | Oldest transmit character |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_count_o | output | 5 | Transmit queue fill count |
| rx_push_i | input | 1 | Push a received character |
| rx_data_i | input | 8 | Received character to push |
| rx_pop_i | input | 1 | Pop the oldest received character |
| rx_data_o | output | 8 | Oldest received character |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_count_o | output | 5 | Receive queue fill count |
| rx_avail_irq_o | output | 1 | Receive-data-available interrupt, level |

## Verification
Every output of this block is a function of registered state and does not depend on the inputs of the same cycle. A corrupted pointer, count, threshold code or flush pulse therefore shows at the ports in the cycle after the clock edge that caused it. A pointer error appears as the wrong head character or a wrong count. A lost or extra flush shows as a count that is not zero, or not expected zero, one edge after the control write. A wrong threshold shows as the interrupt level disagreeing with the count at the boundary character. Comparing every output against a behavioural queue model on each cycle catches such a fault within one clock of its first visible effect.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } rx_trig_e;

  // control register bit positions (read-back layout depends on these)
  localparam int unsigned CTL_EN_BIT    = 0;
  localparam int unsigned CTL_RXCLR_BIT = 1;
  localparam int unsigned CTL_TXCLR_BIT = 2;
  localparam int unsigned CTL_DMA_BIT   = 3;
  localparam int unsigned CTL_TRIG_LSB  = 6;

  function automatic int unsigned trig_bytes(rx_trig_e t);
    case (t)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_ptr_q];

  // flush wins over any transfer in the same cycle
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R1
  AST_FULL_PUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> full_o); // R2
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !clr_i) |=> empty_o); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o); // R9
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o && !clr_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output rx_trig_e   trig_o,
  output logic       tx_flush_o,
  output logic       rx_flush_o,
  output logic [7:0] rdata_o
);
  rx_trig_e trig_q;
  logic     dma_q, tx_flush_q, rx_flush_q;
  logic     wr_ok;
  logic     unused_wbits;

  assign wr_ok        = we_i && wdata_i[CTL_EN_BIT];
  assign unused_wbits = ^wdata_i[5:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q     <= TRIG_1;
      dma_q      <= 1'b0;
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
    end else begin
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
      if (wr_ok) begin
        trig_q     <= rx_trig_e'(wdata_i[CTL_TRIG_LSB +: 2]);
        dma_q      <= wdata_i[CTL_DMA_BIT];
        tx_flush_q <= wdata_i[CTL_TXCLR_BIT];
        rx_flush_q <= wdata_i[CTL_RXCLR_BIT];
      end
    end
  end

  assign trig_o     = trig_q;
  assign tx_flush_o = tx_flush_q;
  assign rx_flush_o = rx_flush_q;
  assign rdata_o    = {trig_q, 2'b00, dma_q, tx_flush_q, rx_flush_q, 1'b1};

  AST_WRITE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[CTL_EN_BIT]) |=>
      ($stable(trig_q) && $stable(dma_q) && !tx_flush_q && !rx_flush_q)); // R4
  AST_TX_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flush_q && !(we_i && wdata_i[CTL_EN_BIT])) |=> !tx_flush_q); // R5
  AST_RX_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flush_q && !(we_i && wdata_i[CTL_EN_BIT])) |=> !rx_flush_q); // R6
endmodule

// File: rtl/rx_level_irq.sv
module rx_level_irq
  import uart_fifo_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  rx_trig_e        trig_i,
  input  logic [CW-1:0]   count_i,
  output logic            irq_o
);
  assign irq_o = 32'(count_i) >= trig_bytes(trig_i);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic [7:0]        ctl_rdata_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  output logic [CNT_W-1:0]  tx_count_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic [CNT_W-1:0]  rx_count_o,
  output logic              rx_avail_irq_o
);
  rx_trig_e trig;
  logic     tx_flush, rx_flush;

  fifo_ctl_reg u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctl_we_i),
    .wdata_i    (ctl_wdata_i),
    .trig_o     (trig),
    .tx_flush_o (tx_flush),
    .rx_flush_o (rx_flush),
    .rdata_o    (ctl_rdata_o)
  );

  byte_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_flush),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o),
    .count_o (tx_count_o)
  );

  byte_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_flush),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .full_o  (rx_full_o),
    .empty_o (rx_empty_o),
    .count_o (rx_count_o)
  );

  rx_level_irq #(.CW(CNT_W)) u_irq (
    .trig_i  (trig),
    .count_i (rx_count_o),
    .irq_o   (rx_avail_irq_o)
  );

  AST_IRQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !rx_avail_irq_o); // R3
  AST_IRQ_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> rx_avail_irq_o); // R3
  AST_RDATA_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[0] && (ctl_rdata_o[5:4] == 2'b00)); // R7
endmodule

// File: tb/uart_fifo_ctrl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       we, txpu, txpo, rxpu, rxpo;
  logic [7:0] wd, txd, rxd;
  logic [7:0] rdata, txq, rxq;
  logic       txf, txe, rxf, rxe, irq;
  logic [4:0] txc, rxc;

  uart_fifo_ctrl u_uart_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(we), .ctl_wdata_i(wd), .ctl_rdata_o(rdata),
    .tx_push_i(txpu), .tx_data_i(txd), .tx_pop_i(txpo), .tx_data_o(txq),
    .tx_full_o(txf), .tx_empty_o(txe), .tx_count_o(txc),
    .rx_push_i(rxpu), .rx_data_i(rxd), .rx_pop_i(rxpo), .rx_data_o(rxq),
    .rx_full_o(rxf), .rx_empty_o(rxe), .rx_count_o(rxc),
    .rx_avail_irq_o(irq)
  );

  // behavioural reference
  byte unsigned m_tx[$], m_rx[$];
  int m_trig;
  bit m_dma, m_txfl, m_rxfl;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic int thr(int t);
    case (t)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk) begin
    int pre;
    if (!rst_n) begin
      m_tx.delete(); m_rx.delete();
      m_trig = 0; m_dma = 0; m_txfl = 0; m_rxfl = 0;
    end else begin
      if (m_txfl) m_tx.delete();
      else begin
        pre = m_tx.size();
        if (txpo && pre > 0) void'(m_tx.pop_front());
        if (txpu && pre < DEPTH) m_tx.push_back(txd);
      end
      if (m_rxfl) m_rx.delete();
      else begin
        pre = m_rx.size();
        if (rxpo && pre > 0) void'(m_rx.pop_front());
        if (rxpu && pre < DEPTH) m_rx.push_back(rxd);
      end
      m_txfl = we && wd[0] && wd[2];
      m_rxfl = we && wd[0] && wd[1];
      if (we && wd[0]) begin
        m_trig = int'(wd[7:6]);
        m_dma  = wd[3];
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 tx_count", int'(txc), m_tx.size());
      check("R1 rx_count", int'(rxc), m_rx.size());
      check("R1 tx_full", int'(txf), int'(m_tx.size() == DEPTH));
      check("R1 tx_empty", int'(txe), int'(m_tx.size() == 0));
      check("R1 rx_full", int'(rxf), int'(m_rx.size() == DEPTH));
      check("R1 rx_empty", int'(rxe), int'(m_rx.size() == 0));
      if (m_tx.size() > 0) check("R1 tx_head", int'(txq), int'(m_tx[0]));
      if (m_rx.size() > 0) check("R1 rx_head", int'(rxq), int'(m_rx[0]));
      check("R3 irq", int'(irq), int'(m_rx.size() >= thr(m_trig)));
      check("R7 rdata", int'(rdata),
            int'({m_trig[1:0], 2'b00, m_dma, m_txfl, m_rxfl, 1'b1}));
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic idle();
    we = 0; wd = 0; txpu = 0; txpo = 0; rxpu = 0; rxpo = 0; txd = 0; rxd = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl(input logic [7:0] v);
    we = 1; wd = v; tick(); we = 0; wd = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    summary();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R8 rdata", int'(rdata), 8'h01);
    check("R8 tx_empty", int'(txe), 1);
    check("R8 rx_empty", int'(rxe), 1);
    check("R8 irq", int'(irq), 0);

    // fill tx past full, then drain past empty
    for (int i = 0; i < 18; i++) begin txpu = 1; txd = 8'h10 + 8'(i); tick(); end
    idle();
    check("R2 tx_count_full", int'(txc), 16);
    check("R2 tx_head_first", int'(txq), 8'h10);
    txpu = 1; txpo = 1; txd = 8'hEE; tick(); idle();
    check("R2 full_push_pop", int'(txc), 15);
    for (int i = 0; i < 18; i++) begin txpo = 1; tick(); end
    idle();
    check("R2 tx_count_empty", int'(txc), 0);

    // simultaneous push/pop in the middle
    for (int i = 0; i < 3; i++) begin txpu = 1; txd = 8'hA0 + 8'(i); tick(); end
    for (int i = 0; i < 5; i++) begin txpu = 1; txpo = 1; txd = 8'hB0 + 8'(i); tick(); end
    idle();
    check("R10 tx_count", int'(txc), 3);
    check("R10 tx_head", int'(txq), 8'hB2);

    // unguarded write: all fields ignored
    ctl(8'hCE);
    check("R4 rdata", int'(rdata), 8'h01);
    tick();
    check("R4 tx_count", int'(txc), 3);
    check("R4 irq_thr1", int'(irq), 0);

    // tx flush
    ctl(8'h05);
    check("R5 pulse_bit", int'(rdata[2]), 1);
    check("R5 tx_before", int'(txc), 3);
    tick();
    check("R5 tx_flushed", int'(txc), 0);
    check("R5 bit_clear", int'(rdata[2]), 0);

    // each threshold: fill rx to full and drain
    for (int t = 0; t < 4; t++) begin
      ctl({2'(t), 6'b000001});
      for (int i = 0; i < DEPTH; i++) begin rxpu = 1; rxd = 8'(t * 16 + i); tick(); end
      idle();
      check("R3 irq_full", int'(irq), 1);
      for (int i = 0; i < DEPTH; i++) begin rxpo = 1; tick(); end
      idle();
      check("R3 irq_empty", int'(irq), 0);
    end

    // dma bit stored without effect
    ctl(8'h49);
    check("R7 rdata_dma", int'(rdata), 8'h49);
    for (int i = 0; i < 4; i++) begin rxpu = 1; rxd = 8'h60 + 8'(i); tick(); end
    idle();
    check("R7 rx_count", int'(rxc), 4);
    check("R3 irq_at4", int'(irq), 1);
    rxpo = 1; tick(); idle();
    check("R3 irq_drop", int'(irq), 0);

    // rx flush
    ctl(8'h03);
    check("R6 pulse_bit", int'(rdata[1]), 1);
    tick();
    check("R6 rx_flushed", int'(rxc), 0);
    check("R6 bit_clear", int'(rdata[1]), 0);

    // flush against push/pop in the pulse cycle
    for (int i = 0; i < 4; i++) begin rxpu = 1; txpu = 1; rxd = 8'h70; txd = 8'h71; tick(); end
    we = 1; wd = 8'h07; tick();
    we = 0; wd = 0; rxpu = 1; txpu = 1; rxpo = 1; tick(); idle();
    check("R9 rx_empty", int'(rxc), 0);
    check("R9 tx_empty", int'(txc), 0);
    tick();
    check("R9 stays_empty", int'(rxe), 1);

    summary();
  end
endmodule